// File: doc/BRIEF.md
# Instruction Line Fill Buffer

This block sits between an instruction fetch unit and the system bus. When a fetch misses and the block is free, it starts a line request on the bus. It then writes each returned read-data beat into a one-line buffer as the beat arrives. A fetch to a word that has already arrived is served from the buffer in the same cycle as the fetch, even while the rest of the transfer is still in flight.

Once a cacheable line is complete, the block either offers the whole line to the instruction cache or keeps it resident. A no-allocate configuration bit keeps the line resident, but a touch-instruction fetch always forces the line into the cache. A non-cacheable line is never offered to the cache. It stays in the buffer as a one-line mini-cache. A second configuration bit sets whether a non-cacheable transfer moves four words or eight words.

Top module: `ifill_buf`

## Requirements
- R1: After reset, fetch_hit_o, req_start_o and cache_wr_valid_o are all low, and no word of the buffer is valid.
- R2: A fetch that misses while no fill is running and no cache write is pending raises req_start_o in the same cycle. The same fetch loads the line tag (address bits 31:5) and clears every word valid bit. req_addr_o gives the byte address of the first word to transfer. req_full_o is high for an eight-word transfer.
- R3: The first beat is stored at the start word, and each later beat goes to the next word. A cacheable line, or a non-cacheable line with cfg_nc_line8_i=1, starts at word 0 and takes 8 beats. A non-cacheable line with cfg_nc_line8_i=0 takes 4 beats into the half of the line picked by fetch address bit 4 (words 0-3 or 4-7).
- R4: fetch_hit_o is high in the same cycle as fetch_valid_i when bits 31:5 of the fetch address equal the tag and the word at bits 4:2 has arrived. fetch_data_o then carries that word. A beat accepted at a clock edge can hit from the next cycle.
- R5: When the last beat of a cacheable line is accepted, cache_wr_valid_o rises in the next cycle. This happens when cfg_no_alloc_i was low at the cycle the request started. cache_wr_line_o carries word i at bits 32i+31:32i, and cache_wr_addr_o carries the line address.
- R6: A cacheable line whose request started with cfg_no_alloc_i high is not offered to the cache. It stays resident and keeps hitting.
- R7: A line whose request started with fetch_touch_i high is offered to the cache even when cfg_no_alloc_i is high.
- R8: A non-cacheable line never raises cache_wr_valid_o. It stays resident and keeps hitting until a new request replaces it.
- R9: cache_wr_valid_o stays high with an unchanged line until cache_wr_ready_i is seen high. While it is high, a missing fetch starts no request.
- R10: While a fill is running, a missing fetch starts no request. Beats that arrive when no fill is running change no buffer content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_no_alloc_i | input | 1 | Keep completed cacheable lines out of the cache |
| cfg_nc_line8_i | input | 1 | Non-cacheable transfer size: 1 = eight words, 0 = four words |
| fetch_valid_i | input | 1 | Fetch request |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_cacheable_i | input | 1 | Fetch target is cacheable |
| fetch_touch_i | input | 1 | Fetch comes from a cache-block-touch instruction |
| fetch_hit_o | output | 1 | Fetched word is present in the buffer |
| fetch_data_o | output | 32 | Fetched instruction word |
| req_start_o | output | 1 | Start a line request this cycle |
| req_addr_o | output | 32 | Byte address of the first word requested |
| req_full_o | output | 1 | Requested transfer is eight words |
| beat_valid_i | input | 1 | Bus read-data beat valid |
| beat_data_i | input | 32 | Bus read-data word |
| cache_wr_valid_o | output | 1 | Line write to the instruction cache requested |
| cache_wr_ready_i | input | 1 | Cache accepts the line write |
| cache_wr_addr_o | output | 32 | Byte address of the written line |
| cache_wr_line_o | output | 256 | Eight-word line to write |

## Verification
A stale tag or a valid bit left set across a new request shows at fetch_hit_o. The symptom is a false hit with old data, seen in the first fetch cycle after the request starts. A fill pointer that drifts puts a beat into the wrong word. This appears as wrong fetch_data_o on the next probe of that word, and as a wrong word in cache_wr_line_o one cycle after the last beat. A wrong allocate flag or a wrong pending flag shows in the cycle after the last beat. Either cache_wr_valid_o takes the wrong level, or req_start_o fires or stays low wrongly on the next miss.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
  typedef struct packed {
    logic cacheable;
    logic alloc;
  } fill_attr_t;
endpackage

// File: rtl/ifb_ctrl.sv
module ifb_ctrl
  import ifb_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [OFF_W-1:0] start_word_i,
  input  logic             full_i,
  input  logic             cacheable_i,
  input  logic             touch_i,
  input  logic             no_alloc_i,
  input  logic             beat_valid_i,
  input  logic             wr_ready_i,
  output logic             filling_o,
  output logic             wr_pend_o,
  output logic             beat_we_o,
  output logic [OFF_W-1:0] beat_idx_o,
  output fill_attr_t       attr_o
);
  localparam int LEFT_W = $clog2(LINE_WORDS + 1);

  logic              filling_q;
  logic              pend_q;
  logic [OFF_W-1:0]  ptr_q;
  logic [LEFT_W-1:0] left_q;
  fill_attr_t        attr_q;
  logic              last_beat;

  assign beat_we_o  = filling_q & beat_valid_i;
  assign last_beat  = beat_we_o && (left_q == LEFT_W'(1));
  assign beat_idx_o = ptr_q;
  assign filling_o  = filling_q;
  assign wr_pend_o  = pend_q;
  assign attr_o     = attr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filling_q <= 1'b0;
      ptr_q     <= '0;
      left_q    <= '0;
      attr_q    <= '0;
    end else if (start_i) begin
      filling_q        <= 1'b1;
      ptr_q            <= start_word_i;
      left_q           <= full_i ? LEFT_W'(LINE_WORDS) : LEFT_W'(LINE_WORDS / 2);
      attr_q.cacheable <= cacheable_i;
      // touch forces allocation regardless of no-allocate
      attr_q.alloc     <= cacheable_i & (touch_i | ~no_alloc_i);
    end else if (beat_we_o) begin
      ptr_q  <= ptr_q + OFF_W'(1);
      left_q <= left_q - LEFT_W'(1);
      if (last_beat) filling_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (pend_q && wr_ready_i) pend_q <= 1'b0;
    else if (last_beat && attr_q.alloc) pend_q <= 1'b1;
  end

  AST_FILL_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat |=> !filling_q); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !filling_q && !pend_q); // R10
endmodule

// File: rtl/ifb_store.sv
module ifb_store #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int TAG_W      = 27,
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic [TAG_W-1:0]             tag_d_i,
  input  logic                         we_i,
  input  logic [OFF_W-1:0]             idx_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [TAG_W-1:0]             tag_o,
  output logic [LINE_WORDS-1:0]        valid_o,
  output logic [LINE_WORDS*DATA_W-1:0] line_o
);
  logic [TAG_W-1:0]      tag_q;
  logic [LINE_WORDS-1:0] valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tag_q <= '0;
    else if (clr_i) tag_q <= tag_d_i;
  end

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              hit_wr;
    assign hit_wr = we_i && (idx_i == OFF_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q     <= '0;
        valid_q[g] <= 1'b0;
      end else if (clr_i) begin
        valid_q[g] <= 1'b0;
      end else if (hit_wr) begin
        word_q     <= data_i;
        valid_q[g] <= 1'b1;
      end
    end
    assign line_o[g*DATA_W +: DATA_W] = word_q;
  end

  assign tag_o   = tag_q;
  assign valid_o = valid_q;

  AST_ONE_WORD_PER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> $countones(valid_q) <= $countones($past(valid_q)) + 1); // R3
endmodule

// File: rtl/ifb_lookup.sv
module ifb_lookup #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int TAG_W      = 27,
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input  logic                         fetch_valid_i,
  input  logic [TAG_W-1:0]             fetch_tag_i,
  input  logic [OFF_W-1:0]             fetch_idx_i,
  input  logic [TAG_W-1:0]             tag_i,
  input  logic [LINE_WORDS-1:0]        valid_i,
  input  logic [LINE_WORDS*DATA_W-1:0] line_i,
  output logic                         hit_o,
  output logic [DATA_W-1:0]            data_o
);
  assign hit_o  = fetch_valid_i && (fetch_tag_i == tag_i) && valid_i[fetch_idx_i];
  assign data_o = line_i[fetch_idx_i*DATA_W +: DATA_W];
endmodule

// File: rtl/ifill_buf.sv
module ifill_buf
  import ifb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_no_alloc_i,
  input  logic                         cfg_nc_line8_i,
  input  logic                         fetch_valid_i,
  input  logic [ADDR_W-1:0]            fetch_addr_i,
  input  logic                         fetch_cacheable_i,
  input  logic                         fetch_touch_i,
  output logic                         fetch_hit_o,
  output logic [DATA_W-1:0]            fetch_data_o,
  output logic                         req_start_o,
  output logic [ADDR_W-1:0]            req_addr_o,
  output logic                         req_full_o,
  input  logic                         beat_valid_i,
  input  logic [DATA_W-1:0]            beat_data_i,
  output logic                         cache_wr_valid_o,
  input  logic                         cache_wr_ready_i,
  output logic [ADDR_W-1:0]            cache_wr_addr_o,
  output logic [LINE_WORDS*DATA_W-1:0] cache_wr_line_o
);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int TAG_W  = ADDR_W - OFF_W - BYTE_W;

  logic [TAG_W-1:0]      fetch_tag, buf_tag;
  logic [OFF_W-1:0]      fetch_idx, start_word, beat_idx;
  logic [LINE_WORDS-1:0] valid;
  logic                  filling, wr_pend, beat_we, full, start;
  fill_attr_t            attr;

  assign fetch_tag  = fetch_addr_i[ADDR_W-1 -: TAG_W];
  assign fetch_idx  = fetch_addr_i[BYTE_W +: OFF_W];
  assign full       = fetch_cacheable_i | cfg_nc_line8_i;
  assign start_word = full ? '0 : {fetch_idx[OFF_W-1], {(OFF_W-1){1'b0}}};
  assign start      = fetch_valid_i & ~fetch_hit_o & ~filling & ~wr_pend;

  assign req_start_o      = start;
  assign req_addr_o       = {fetch_tag, start_word, {BYTE_W{1'b0}}};
  assign req_full_o       = full;
  assign cache_wr_valid_o = wr_pend;
  assign cache_wr_addr_o  = {buf_tag, {(OFF_W + BYTE_W){1'b0}}};

  ifb_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_word_i (start_word),
    .full_i       (full),
    .cacheable_i  (fetch_cacheable_i),
    .touch_i      (fetch_touch_i),
    .no_alloc_i   (cfg_no_alloc_i),
    .beat_valid_i (beat_valid_i),
    .wr_ready_i   (cache_wr_ready_i),
    .filling_o    (filling),
    .wr_pend_o    (wr_pend),
    .beat_we_o    (beat_we),
    .beat_idx_o   (beat_idx),
    .attr_o       (attr)
  );

  ifb_store #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start),
    .tag_d_i (fetch_tag),
    .we_i    (beat_we),
    .idx_i   (beat_idx),
    .data_i  (beat_data_i),
    .tag_o   (buf_tag),
    .valid_o (valid),
    .line_o  (cache_wr_line_o)
  );

  ifb_lookup #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_lookup (
    .fetch_valid_i (fetch_valid_i),
    .fetch_tag_i   (fetch_tag),
    .fetch_idx_i   (fetch_idx),
    .tag_i         (buf_tag),
    .valid_i       (valid),
    .line_i        (cache_wr_line_o),
    .hit_o         (fetch_hit_o),
    .data_o        (fetch_data_o)
  );

  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_wr_valid_o && !cache_wr_ready_i |=> cache_wr_valid_o && $stable(cache_wr_line_o)); // R9
  AST_WR_FULL_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cache_wr_valid_o) |-> (&valid)); // R5
  AST_NC_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_wr_valid_o |-> attr.cacheable); // R8
  AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_start_o |=> (valid == '0)); // R2
  AST_BEAT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !filling && beat_valid_i && !req_start_o |=> $stable(valid) && $stable(cache_wr_line_o)); // R10
endmodule

// File: tb/sim_ifill_buf.sv
module sim_ifill_buf;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         no_alloc = 1'b0, nc8 = 1'b0;
  logic         fv = 1'b0, fc = 1'b0, ft = 1'b0;
  logic [31:0]  fa = '0;
  logic         bv = 1'b0;
  logic [31:0]  bd = '0;
  logic         wready = 1'b0;
  logic         hit, rstart, rfull, wvalid;
  logic [31:0]  fdata, raddr, waddr;
  logic [255:0] wline;

  always #10 clk = ~clk;

  ifill_buf u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_no_alloc_i(no_alloc), .cfg_nc_line8_i(nc8),
    .fetch_valid_i(fv), .fetch_addr_i(fa), .fetch_cacheable_i(fc), .fetch_touch_i(ft),
    .fetch_hit_o(hit), .fetch_data_o(fdata), .req_start_o(rstart), .req_addr_o(raddr),
    .req_full_o(rfull), .beat_valid_i(bv), .beat_data_i(bd), .cache_wr_valid_o(wvalid),
    .cache_wr_ready_i(wready), .cache_wr_addr_o(waddr), .cache_wr_line_o(wline)
  );

  int n_cmp = 0, n_bad = 0;
  int dv = 0;

  // reference model state
  logic [31:0] mw[8];
  bit          mv[8];
  logic [26:0] mtag;
  bit          mfill, malloc, mpend;
  int          mptr, mleft;

  task automatic chk(string req, string what, logic [255:0] act, logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin mw[i] = '0; mv[i] = 0; end
    mtag = '0; mfill = 0; malloc = 0; mpend = 0; mptr = 0; mleft = 0;
  endtask

  // called at negedge with inputs set; checks, then advances one clock
  task automatic cyc(string req);
    bit ehit, estart, full;
    int fi, sw;
    logic [26:0] fl;
    logic [255:0] eline;
    #5;
    fl = fa[31:5];
    fi = int'(fa[4:2]);
    ehit   = fv && (fl == mtag) && mv[fi];
    estart = fv && !ehit && !mfill && !mpend;
    full   = fc || nc8;
    sw     = full ? 0 : (fi & 4);
    chk(req, "R4 hit", 256'(hit), 256'(ehit));
    if (ehit) chk(req, "R4 data", 256'(fdata), 256'(mw[fi]));
    chk(req, "R2 start", 256'(rstart), 256'(estart));
    if (estart) begin
      chk(req, "R2 addr", 256'(raddr), 256'({fl, 3'(sw), 2'b00}));
      chk(req, "R2 full", 256'(rfull), 256'(full));
    end
    chk(req, "R9 wvalid", 256'(wvalid), 256'(mpend));
    if (mpend) begin
      for (int i = 0; i < 8; i++) eline[32*i +: 32] = mw[i];
      chk(req, "R5 line", wline, eline);
      chk(req, "R5 waddr", 256'(waddr), 256'({mtag, 5'b0}));
    end
    @(posedge clk);
    if (mpend && wready) mpend = 0;
    if (mfill && bv) begin
      mw[mptr] = bd; mv[mptr] = 1; mptr++; mleft--;
      if (mleft == 0) begin mfill = 0; if (malloc) mpend = 1; end
    end
    if (estart) begin
      mtag = fl;
      for (int i = 0; i < 8; i++) mv[i] = 0;
      mfill = 1; mptr = sw; mleft = full ? 8 : 4;
      malloc = fc && (ft || !no_alloc);
    end
    @(negedge clk);
  endtask

  task automatic fetch(logic [31:0] a, bit c, bit t, string req);
    fv = 1; fa = a; fc = c; ft = t; cyc(req);
  endtask

  // n beats, each followed by an idle cycle probing address p
  task automatic fill(int n, logic [31:0] p, string req);
    for (int i = 0; i < n; i++) begin
      fv = 1; fa = p; fc = 1; ft = 0;
      bv = 1; dv++; bd = 32'hA500_0000 ^ (dv * 32'h0101_0033);
      cyc(req);
      bv = 0; cyc(req);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    // R1: outputs idle during and after reset
    cyc("R1"); cyc("R1");
    rst_n = 1'b1;
    cyc("R1");
    fetch(32'h0000_1048, 1, 0, "R1");  // empty buffer: miss, start

    // R3 R4 R10 R5: cacheable fill, probe word 2, then other-line miss mid-fill
    fill(3, 32'h0000_1048, "R4");
    fill(2, 32'h0000_2000, "R10");
    fill(3, 32'h0000_105C, "R3");
    // R9: write pending, ready low, misses start nothing
    wready = 0;
    repeat (3) fetch(32'h0000_2000, 1, 0, "R9");
    wready = 1; fv = 0; cyc("R9");
    wready = 0; cyc("R9");

    // R10: beats while idle change nothing
    bv = 1; bd = 32'hDEAD_BEEF;
    fetch(32'h0000_1048, 1, 0, "R10");
    fetch(32'h0000_1050, 1, 0, "R10");
    bv = 0; fetch(32'h0000_1048, 1, 0, "R10");

    // R6: no-allocate cacheable line stays resident
    no_alloc = 1;
    fetch(32'h0000_3000, 1, 0, "R6");
    fill(8, 32'h0000_3004, "R6");
    repeat (3) fetch(32'h0000_301C, 1, 0, "R6");

    // R7: touch overrides no-allocate
    fetch(32'h0000_4008, 1, 1, "R7");
    ft = 0;
    fill(8, 32'h0000_4008, "R7");
    wready = 1; fv = 0; cyc("R7");
    wready = 0; cyc("R7");
    no_alloc = 0;

    // R8 R3: non-cacheable four-word fill into upper half
    nc8 = 0;
    fetch(32'h0000_5014, 0, 0, "R8");
    fill(4, 32'h0000_5014, "R3");
    fetch(32'h0000_501C, 0, 0, "R8");
    fetch(32'h0000_5010, 0, 0, "R8");
    fetch(32'h0000_5004, 0, 0, "R3");  // lower half absent: new request
    fill(4, 32'h0000_5004, "R3");
    fetch(32'h0000_500C, 0, 0, "R8");

    // R8: non-cacheable eight-word fill
    nc8 = 1;
    fetch(32'h0000_6018, 0, 0, "R8");
    fill(8, 32'h0000_6000, "R8");
    repeat (2) fetch(32'h0000_6018, 0, 0, "R8");
    fv = 0; cyc("R8"); cyc("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule